// File: doc/BRIEF.md
# Interrupt Request Aggregator

This block gathers interrupt requests from ten sources beside an 8051-style CPU core: two external pins, three timers, two serial ports, an I2C controller, a display data channel (DDC) controller and a USB device. It keeps a request flag for each origin and applies that origin's own clearing rule. Some flags are cleared by hardware when the CPU takes the vector. Some stay set until software writes a clear. The external pins in level mode simply follow the pin.

A global enable and a per-source mask gate the pending requests. A fixed-priority arbiter picks the lowest-numbered enabled request and offers its index to the CPU with a valid strobe. The offer holds until the CPU pulses acknowledge. The acknowledge also fires the hardware clear of the chosen source. After that the arbiter stays locked until the CPU signals end of service.

A select input lets the converter's conversion-done event stand in for the second external pin.

Top module: `intreq_hub`

## Requirements
- R1: Source indices are fixed: 0 ext pin A, 1 second UART, 2 timer 0, 3 I2C, 4 ext pin B or converter, 5 DDC, 6 timer 1, 7 USB, 8 UART, 9 timer 2. Among enabled pending sources, the lowest index wins, and `vec_idx` carries it in binary.
- R2: A source is offered only when both `glob_en` and its bit in `src_en` are 1. A masked request stays pending and is offered once it is enabled.
- R3: After reset, `vec_valid` is 0 and every latched flag is clear. A one-cycle event pulse sampled at clock edge k gives `vec_valid` after edge k+1, and not before. A pin change needs two extra edges for synchronization.
- R4: While `vec_valid` is 1 and `ack` is 0, `vec_valid` and `vec_idx` stay unchanged, even when a higher-priority request arrives.
- R5: `ack` during an offer drops `vec_valid` at the next edge. No new offer appears until `eos` is pulsed. Arbitration resumes on the edge after `eos`.
- R6: With `ext0_edge`/`ext1_edge` at 1, a high-to-low change of the synchronized pin sets the flag, and acknowledging that source clears it. A pin that stays low does not request again.
- R7: With the edge select at 0, the request follows the synchronized pin being low. Acknowledge does not clear it, so a pin still low after `eos` is offered again.
- R8: With `adc_sel` at 1, source 4 ignores pin B. Instead, an `adc_done` pulse sets a flag that acknowledge clears.
- R9: The timer 0, timer 1 and I2C flags are set by their event pulses and cleared when their vector is acknowledged.
- R10: The timer 2 request is the OR of an overflow flag and an external-event flag. The external-event flag sets only while `tmr2_ext_en` is 1. Acknowledge clears neither flag. `sw_clr_tmr2` bit 0 clears the overflow flag and bit 1 clears the external-event flag.
- R11: The DDC request is the OR of a serial-status flag, a DDC1 event flag and a protocol-switch flag. Only the serial-status flag is cleared by acknowledge. `sw_clr_ddc` bit 0 clears the DDC1 flag and bit 1 clears the switch flag.
- R12: The USB request is the OR of seven event flags. The `usb_evt`/`sw_clr_usb` bits are: 0 EP0 sent, 1 EP0 received, 2 EP1 sent, 3 EP2 sent, 4 suspend, 5 resume, 6 end of packet. Only the matching `sw_clr_usb` bit clears each flag.
- R13: The two UART requests are level inputs passed straight to the arbiter, with no latching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext0_n | input | 1 | External pin A, active low, asynchronous |
| ext1_n | input | 1 | External pin B, active low, asynchronous |
| ext0_edge | input | 1 | Pin A: 1 = falling-transition, 0 = level |
| ext1_edge | input | 1 | Pin B: 1 = falling-transition, 0 = level |
| adc_sel | input | 1 | Converter replaces pin B on source 4 |
| adc_done | input | 1 | Conversion-complete pulse |
| uart_req | input | 1 | UART request level |
| uart2_req | input | 1 | Second UART request level |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| tmr2_ovf | input | 1 | Timer 2 overflow pulse |
| tmr2_ext_evt | input | 1 | Timer 2 external event pulse |
| tmr2_ext_en | input | 1 | Allows the timer 2 external event to set its flag |
| i2c_evt | input | 1 | I2C event pulse |
| ddc_ser_evt | input | 1 | DDC serial-status event pulse |
| ddc1_evt | input | 1 | DDC1 event pulse |
| ddc_sw_evt | input | 1 | DDC1-to-DDC2 switch pulse |
| usb_evt | input | USB_EVW | USB event pulses |
| sw_clr_tmr2 | input | 2 | Software clears for timer 2 flags |
| sw_clr_ddc | input | 2 | Software clears for DDC flags |
| sw_clr_usb | input | USB_EVW | Software clears for USB flags |
| glob_en | input | 1 | Global interrupt enable |
| src_en | input | NSRC | Per-source enable mask |
| ack | input | 1 | CPU takes the offered vector |
| eos | input | 1 | End of service routine |
| vec_valid | output | 1 | Offer valid |
| vec_idx | output | IDXW | Offered source index |

## Verification
A flag with the wrong clearing rule shows up a few cycles after `eos`. A hardware-cleared source re-offers when it should not. A software-cleared or level source fails to re-offer when it should. In either case it is seen within three edges of end of service. A stuck lock or a broken hold shows on `vec_valid` at the edge right after `ack` or `eos`. A wrong priority shows on `vec_idx` at the first offer after several events arrive together.

// File: rtl/intreq_hub_pkg.sv
package intreq_hub_pkg;
    localparam int NSRC    = 10;
    localparam int IDXW    = $clog2(NSRC);
    localparam int USB_EVW = 7;

    // fixed source numbering; a lower number wins arbitration
    localparam int S_EXT0  = 0;
    localparam int S_UART2 = 1;
    localparam int S_TMR0  = 2;
    localparam int S_I2C   = 3;
    localparam int S_EXT1  = 4;
    localparam int S_DDC   = 5;
    localparam int S_TMR1  = 6;
    localparam int S_USB   = 7;
    localparam int S_UART  = 8;
    localparam int S_TMR2  = 9;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_n,
    output logic [W-1:0] low,
    output logic [W-1:0] fall
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
        logic [W-1:0]             prev;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d          = q;
        d.chain[0] = pin_n;
        for (int i = 1; i < STAGES; i++) begin
            d.chain[i] = q.chain[i-1];
        end
        d.prev = q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;      // pins idle high
        else        q <= d;
    end

    assign low  = ~q.chain[STAGES-1];
    assign fall = q.prev & ~q.chain[STAGES-1];
endmodule

// File: rtl/irq_ext_flag.sv
module irq_ext_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_mode,
    input  logic low,
    input  logic fall,
    input  logic alt_sel,
    input  logic alt_evt,
    input  logic hw_clr,
    output logic req
);
    typedef struct packed {
        logic flag;
    } ext_t;

    ext_t d, q;

    always_comb begin
        d = q;
        if (alt_sel) begin
            d.flag = alt_evt | (q.flag & ~hw_clr);
        end else if (edge_mode) begin
            d.flag = fall | (q.flag & ~hw_clr);
        end else begin
            d.flag = low;          // level mode: tracks the pin
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req = q.flag;
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] hw_clr,
    input  logic [W-1:0] sw_clr,
    output logic [W-1:0] flags
);
    typedef struct packed {
        logic [W-1:0] f;
    } bank_t;

    bank_t d, q;

    always_comb begin
        d = q;
        for (int i = 0; i < W; i++) begin
            d.f[i] = set[i] | (q.f[i] & ~hw_clr[i] & ~sw_clr[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign flags = q.f;
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
    parameter int N = 10,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          ack,
    input  logic          eos,
    output logic          valid,
    output logic [IW-1:0] idx,
    output logic          busy,
    output logic [N-1:0]  grant
);
    typedef struct packed {
        logic          valid;
        logic          in_svc;
        logic [IW-1:0] idx;
    } arb_t;

    arb_t          d, q;
    logic [IW-1:0] first;
    logic          hit;
    logic          take;

    always_comb begin
        first = '0;
        hit   = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                first = IW'(i);
                hit   = 1'b1;
            end
        end
    end

    assign take = q.valid & ack;

    always_comb begin
        d = q;
        if (q.valid) begin
            if (ack) begin
                d.valid  = 1'b0;
                d.in_svc = 1'b1;
            end
        end else if (q.in_svc) begin
            if (eos) d.in_svc = 1'b0;
        end else if (hit) begin
            d.valid = 1'b1;
            d.idx   = first;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            grant[i] = take && (q.idx == IW'(i));
        end
    end

    assign valid = q.valid;
    assign idx   = q.idx;
    assign busy  = q.in_svc;
endmodule

// File: rtl/intreq_hub.sv
module intreq_hub
    import intreq_hub_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int UEW         = USB_EVW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ext0_n,
    input  logic            ext1_n,
    input  logic            ext0_edge,
    input  logic            ext1_edge,
    input  logic            adc_sel,
    input  logic            adc_done,
    input  logic            uart_req,
    input  logic            uart2_req,
    input  logic            tmr0_ovf,
    input  logic            tmr1_ovf,
    input  logic            tmr2_ovf,
    input  logic            tmr2_ext_evt,
    input  logic            tmr2_ext_en,
    input  logic            i2c_evt,
    input  logic            ddc_ser_evt,
    input  logic            ddc1_evt,
    input  logic            ddc_sw_evt,
    input  logic [UEW-1:0]  usb_evt,
    input  logic [1:0]      sw_clr_tmr2,
    input  logic [1:0]      sw_clr_ddc,
    input  logic [UEW-1:0]  sw_clr_usb,
    input  logic            glob_en,
    input  logic [NSRC-1:0] src_en,
    input  logic            ack,
    input  logic            eos,
    output logic            vec_valid,
    output logic [IDXW-1:0] vec_idx
);
    localparam int NEXT = 2;
    localparam int HW_W = 4;
    localparam int SW_W = 4 + UEW;

    logic [NEXT-1:0] pin_low, pin_fall, ext_req, ext_edge, ext_alt_sel, ext_alt_evt, ext_hwclr;
    logic [HW_W-1:0] hw_set, hw_clr, hw_flags;
    logic [SW_W-1:0] sw_set, sw_clr, sw_flags;
    logic [NSRC-1:0] src_req, masked, grant;
    logic            busy;

    irq_pin_sync #(.W(NEXT), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n ({ext1_n, ext0_n}),
        .low   (pin_low),
        .fall  (pin_fall)
    );

    assign ext_edge    = {ext1_edge, ext0_edge};
    assign ext_alt_sel = {adc_sel, 1'b0};
    assign ext_alt_evt = {adc_done, 1'b0};
    assign ext_hwclr   = {grant[S_EXT1], grant[S_EXT0]};

    for (genvar g = 0; g < NEXT; g++) begin : g_ext
        irq_ext_flag u_flag (
            .clk       (clk),
            .rst_n     (rst_n),
            .edge_mode (ext_edge[g]),
            .low       (pin_low[g]),
            .fall      (pin_fall[g]),
            .alt_sel   (ext_alt_sel[g]),
            .alt_evt   (ext_alt_evt[g]),
            .hw_clr    (ext_hwclr[g]),
            .req       (ext_req[g])
        );
    end

    // bank of flags cleared by taking the vector: tmr0, i2c, tmr1, ddc serial
    assign hw_set = {ddc_ser_evt, tmr1_ovf, i2c_evt, tmr0_ovf};
    assign hw_clr = {grant[S_DDC], grant[S_TMR1], grant[S_I2C], grant[S_TMR0]};

    irq_flag_bank #(.W(HW_W)) u_hw_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (hw_set),
        .hw_clr (hw_clr),
        .sw_clr ('0),
        .flags  (hw_flags)
    );

    // bank of flags cleared only by software:
    // [0] tmr2 ovf, [1] tmr2 ext, [2] ddc1, [3] ddc switch, [4+] usb events
    assign sw_set = {usb_evt, ddc_sw_evt, ddc1_evt, tmr2_ext_evt & tmr2_ext_en, tmr2_ovf};
    assign sw_clr = {sw_clr_usb, sw_clr_ddc, sw_clr_tmr2};

    irq_flag_bank #(.W(SW_W)) u_sw_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (sw_set),
        .hw_clr ('0),
        .sw_clr (sw_clr),
        .flags  (sw_flags)
    );

    always_comb begin
        src_req          = '0;
        src_req[S_EXT0]  = ext_req[0];
        src_req[S_UART2] = uart2_req;
        src_req[S_TMR0]  = hw_flags[0];
        src_req[S_I2C]   = hw_flags[1];
        src_req[S_EXT1]  = ext_req[1];
        src_req[S_DDC]   = hw_flags[3] | sw_flags[2] | sw_flags[3];
        src_req[S_TMR1]  = hw_flags[2];
        src_req[S_USB]   = |sw_flags[SW_W-1:4];
        src_req[S_UART]  = uart_req;
        src_req[S_TMR2]  = sw_flags[0] | sw_flags[1];
    end

    assign masked = src_req & src_en & {NSRC{glob_en}};

    irq_prio_arb #(.N(NSRC)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (masked),
        .ack   (ack),
        .eos   (eos),
        .valid (vec_valid),
        .idx   (vec_idx),
        .busy  (busy),
        .grant (grant)
    );
endmodule

// File: rtl/intreq_hub_chk.sv
module intreq_hub_chk
    import intreq_hub_pkg::*;
#(
    parameter int UEW = USB_EVW
) (
    input logic            clk,
    input logic            rst_n,
    input logic            glob_en,
    input logic            ack,
    input logic            eos,
    input logic            tmr0_ovf,
    input logic [UEW-1:0]  sw_clr_usb,
    input logic            vec_valid,
    input logic [IDXW-1:0] vec_idx,
    input logic            busy,
    input logic [NSRC-1:0] src_req
);
    p_idx_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (vec_idx < IDXW'(NSRC)));

    p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_valid) |-> $past(glob_en));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !ack) |=> (vec_valid && $stable(vec_idx)));

    p_ack_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && ack) |=> !vec_valid);

    p_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !eos) |=> !vec_valid);

    p_hw_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && ack && vec_idx == IDXW'(S_TMR0) && !tmr0_ovf) |=> !src_req[S_TMR0]);

    p_usb_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && ack && vec_idx == IDXW'(S_USB) && src_req[S_USB] && sw_clr_usb == '0)
        |=> src_req[S_USB]);
endmodule

bind intreq_hub intreq_hub_chk #(.UEW(UEW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .glob_en    (glob_en),
    .ack        (ack),
    .eos        (eos),
    .tmr0_ovf   (tmr0_ovf),
    .sw_clr_usb (sw_clr_usb),
    .vec_valid  (vec_valid),
    .vec_idx    (vec_idx),
    .busy       (busy),
    .src_req    (src_req)
);

// File: tb/sim_intreq_hub.sv
`timescale 1ns/1ps
module sim_intreq_hub;
    import intreq_hub_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext0_n = 1'b1, ext1_n = 1'b1, ext0_edge = 1'b1, ext1_edge = 1'b1;
    logic adc_sel = 1'b0, adc_done = 1'b0, uart_req = 1'b0, uart2_req = 1'b0;
    logic tmr0_ovf = 1'b0, tmr1_ovf = 1'b0, tmr2_ovf = 1'b0, tmr2_ext_evt = 1'b0;
    logic tmr2_ext_en = 1'b1, i2c_evt = 1'b0;
    logic ddc_ser_evt = 1'b0, ddc1_evt = 1'b0, ddc_sw_evt = 1'b0;
    logic [USB_EVW-1:0] usb_evt = '0, sw_clr_usb = '0;
    logic [1:0] sw_clr_tmr2 = '0, sw_clr_ddc = '0;
    logic glob_en = 1'b1;
    logic [NSRC-1:0] src_en = '1;
    logic ack = 1'b0, eos = 1'b0;
    logic vec_valid;
    logic [IDXW-1:0] vec_idx;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    intreq_hub u0 (.*);

    // {mask[24:15], fire[14:5], exp_valid[4], exp_idx[3:0]}
    localparam logic [24:0] VEC [0:7] = '{
        {10'h3FF,        10'b0001000100, 1'b1, 4'd2},
        {10'h3FF,        10'b1001000000, 1'b1, 4'd6},
        {10'b1111111011, 10'b0000001100, 1'b1, 4'd3},
        {10'h3FF,        10'b0010100000, 1'b1, 4'd5},
        {10'h3FF,        10'b1000000000, 1'b1, 4'd9},
        {10'h000,        10'b0000000100, 1'b0, 4'd0},
        {10'h3FF,        10'b0100000010, 1'b1, 4'd1},
        {10'b1111110111, 10'b1010001000, 1'b1, 4'd7}
    };

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic offer(input string tag, input int exp_idx);
        check({tag, " valid"}, int'(vec_valid), 1);
        check({tag, " idx"}, int'(vec_idx), exp_idx);
    endtask

    task automatic pulse_ack;  ack = 1'b1; cyc(1); ack = 1'b0; endtask
    task automatic pulse_eos;  eos = 1'b1; cyc(1); eos = 1'b0; endtask
    task automatic service;    pulse_ack(); pulse_eos(); cyc(3); endtask

    task automatic fire(input logic [9:0] m);
        uart2_req   = uart2_req | m[S_UART2];
        uart_req    = uart_req  | m[S_UART];
        tmr0_ovf    = m[S_TMR0];
        i2c_evt     = m[S_I2C];
        ddc_ser_evt = m[S_DDC];
        tmr1_ovf    = m[S_TMR1];
        usb_evt[6]  = m[S_USB];
        tmr2_ovf    = m[S_TMR2];
        cyc(1);
        tmr0_ovf = 1'b0; i2c_evt = 1'b0; ddc_ser_evt = 1'b0;
        tmr1_ovf = 1'b0; usb_evt = '0; tmr2_ovf = 1'b0;
    endtask

    task automatic drain;
        src_en = '1; glob_en = 1'b1; uart_req = 1'b0; uart2_req = 1'b0;
        sw_clr_tmr2 = '1; sw_clr_ddc = '1; sw_clr_usb = '1;
        cyc(1);
        sw_clr_tmr2 = '0; sw_clr_ddc = '0; sw_clr_usb = '0;
        repeat (14) begin
            if (vec_valid) pulse_ack();
            pulse_eos();
            cyc(2);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(3);
        check("R3 reset valid", int'(vec_valid), 0);

        // R3 latency: pulse seen at edge k, offer after edge k+1
        tmr0_ovf = 1'b1; cyc(1); tmr0_ovf = 1'b0;
        check("R3 not yet", int'(vec_valid), 0);
        cyc(1);
        offer("R3 offer", S_TMR0);
        drain();

        // R1 R2 table walk
        for (int i = 0; i < 8; i++) begin
            src_en = VEC[i][24:15];
            fire(VEC[i][14:5]);
            cyc(3);
            check($sformatf("R1 R2 vec%0d valid", i), int'(vec_valid), int'(VEC[i][4]));
            if (VEC[i][4]) check($sformatf("R1 vec%0d idx", i), int'(vec_idx), int'(VEC[i][3:0]));
            drain();
        end

        // R4 hold and R5 lock; R9 timer1 cleared by ack
        fire(10'b0001000000); cyc(3);
        offer("R4 first", S_TMR1);
        fire(10'b0000000100); cyc(3);
        offer("R4 held", S_TMR1);
        pulse_ack(); cyc(3);
        check("R5 locked", int'(vec_valid), 0);
        pulse_eos(); cyc(1);
        offer("R5 resume", S_TMR0);
        service();
        check("R9 tmr hw cleared", int'(vec_valid), 0);
        drain();

        // R2 global gate keeps request pending
        glob_en = 1'b0;
        fire(10'b0000001000); cyc(4);
        check("R2 gated", int'(vec_valid), 0);
        glob_en = 1'b1; cyc(3);
        offer("R2 released", S_I2C);
        service();
        check("R9 i2c hw cleared", int'(vec_valid), 0);
        drain();

        // R6 edge mode on pin A
        ext0_edge = 1'b1; ext0_n = 1'b0; cyc(6);
        offer("R6 edge", S_EXT0);
        service(); cyc(2);
        check("R6 cleared, pin still low", int'(vec_valid), 0);
        ext0_n = 1'b1; drain();

        // R7 level mode on pin A
        ext0_edge = 1'b0; ext0_n = 1'b0; cyc(6);
        offer("R7 level", S_EXT0);
        service();
        offer("R7 re-request", S_EXT0);
        ext0_n = 1'b1; cyc(5);
        service();
        check("R7 released", int'(vec_valid), 0);
        ext0_edge = 1'b1; drain();

        // R8 converter takeover of source 4
        ext1_edge = 1'b0; adc_sel = 1'b1; ext1_n = 1'b0; cyc(6);
        check("R8 pin ignored", int'(vec_valid), 0);
        adc_done = 1'b1; cyc(1); adc_done = 1'b0; cyc(2);
        offer("R8 adc", S_EXT1);
        service();
        check("R8 adc cleared", int'(vec_valid), 0);
        adc_sel = 1'b0; cyc(3);
        offer("R8 pin back", S_EXT1);
        ext1_n = 1'b1; cyc(5);
        service(); ext1_edge = 1'b1; drain();

        // R10 timer 2
        fire(10'b1000000000); cyc(3);
        offer("R10 ovf", S_TMR2);
        service();
        offer("R10 survives ack", S_TMR2);
        sw_clr_tmr2 = 2'b01; cyc(1); sw_clr_tmr2 = '0;
        service();
        check("R10 sw cleared", int'(vec_valid), 0);
        tmr2_ext_en = 1'b0;
        tmr2_ext_evt = 1'b1; cyc(1); tmr2_ext_evt = 1'b0; cyc(3);
        check("R10 ext gated", int'(vec_valid), 0);
        tmr2_ext_en = 1'b1;
        tmr2_ext_evt = 1'b1; cyc(1); tmr2_ext_evt = 1'b0; cyc(3);
        offer("R10 ext", S_TMR2);
        drain();

        // R11 DDC
        fire(10'b0000100000); cyc(3);
        offer("R11 serial", S_DDC);
        service();
        check("R11 serial hw cleared", int'(vec_valid), 0);
        ddc_sw_evt = 1'b1; cyc(1); ddc_sw_evt = 1'b0; cyc(3);
        offer("R11 switch", S_DDC);
        service();
        offer("R11 switch survives", S_DDC);
        sw_clr_ddc = 2'b10; cyc(1); sw_clr_ddc = '0;
        service();
        check("R11 switch sw cleared", int'(vec_valid), 0);
        drain();

        // R12 USB suspend flag
        usb_evt[4] = 1'b1; cyc(1); usb_evt = '0; cyc(3);
        offer("R12 usb", S_USB);
        service();
        offer("R12 survives", S_USB);
        sw_clr_usb = 7'b0010000; cyc(1); sw_clr_usb = '0;
        service();
        check("R12 sw cleared", int'(vec_valid), 0);
        drain();

        // R13 UART level passes through, unlatched
        uart_req = 1'b1; cyc(2);
        offer("R13 uart", S_UART);
        uart_req = 1'b0;
        service();
        check("R13 no latch", int'(vec_valid), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule